// File: doc/BRIEF.md
# Load-Tracking Valley Skip Counter

This block keeps a small count of how many ringing valleys (zero crossings of the demagnetisation ringing) a quasi-resonant flyback controller lets pass before it turns the switch on again. The gate timing logic next to it compares its own crossing tally with this count. A light load raises the count, which lengthens the off-time and lowers the switching frequency. A heavy load lowers it. A sudden load step forces the count back to one, so the converter can deliver full power at once.

The block reads three range flags from an external comparator bank on the feedback voltage: low (below the upward threshold), high (above the downward threshold) and surge (above the reset threshold). The low and high flags are held in two sticky bits between update ticks. On each tick the count moves one step or holds, and then both sticky bits clear. The surge flag does not wait for a tick. The tick is made by an internal prescaler on the system clock, or it is taken from an input pin. A parameter chooses which.

Top module: `valley_skip_ctrl`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `skip_cnt` reads 1 (4'b0001).
- R2: If `fb_low` was high in any cycle since the previous tick, or is high in the tick cycle, and no high flag applies, `skip_cnt` rises by one on the edge that ends the tick cycle.
- R3: If `fb_high` was high in any cycle since the previous tick, or is high in the tick cycle, `skip_cnt` falls by one on the edge that ends the tick cycle.
- R4: If neither flag was seen in the period, `skip_cnt` holds at the tick. Between ticks `skip_cnt` changes only through `fb_surge`.
- R5: When `fb_surge` is high in a cycle, `skip_cnt` reads 1 from the next edge on, whatever the tick state. This takes priority over any tick step.
- R6: A flag pulse of one cycle anywhere inside a period is acted on at the next tick. Both sticky bits clear at the tick, so each captured condition moves the count only once.
- R7: When both low and high were seen in the same period, the step is a decrement.
- R8: An increment stops at 15 (4'b1111) and a decrement stops at 1. `skip_cnt` never reads 0.
- R9: With the internal tick source, a one-cycle tick occurs every `TICK_DIV` clock cycles. The first tick is high in the cycle after the `TICK_DIV`-th edge following reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_low | input | 1 | Feedback voltage below the upward-step threshold |
| fb_high | input | 1 | Feedback voltage above the downward-step threshold |
| fb_surge | input | 1 | Feedback voltage above the reset-to-one threshold |
| ext_tick | input | 1 | External period pulse, used only when `TICK_INTERNAL` is 0 |
| skip_cnt | output | CNT_W | Number of zero crossings to skip (registered) |

## Verification
The hardest case to reach from the ports is a period in which both sticky bits were set by short pulses that ended long before the tick, possibly followed by a surge that resets the count while the sticky bits are still armed. The stimulus drives sparse one-cycle pulses on the low and high flags at random points in each period, and rare surge pulses. It also includes directed phases that run the count into both saturation limits. A cycle-accurate reference in the bench, built from the requirements, predicts `skip_cnt` for every cycle.

// File: rtl/vs_pkg.sv
package vs_pkg;
  typedef struct packed {
    logic low;
    logic high;
  } vs_range_t;
endpackage

// File: rtl/vs_tick_gen.sv
module vs_tick_gen #(
  parameter bit          TICK_INTERNAL = 1'b1,
  parameter int unsigned TICK_DIV      = 5000000
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_tick,
  output logic tick
);
  generate
    if (TICK_INTERNAL) begin : g_int
      localparam int unsigned DW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
      localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      logic          tick_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          div_q  <= (div_q == LAST) ? '0 : div_q + 1'b1;
          tick_q <= (div_q == LAST);
        end
      end
      assign tick = tick_q;

      if (TICK_DIV > 1) begin : g_chk
        AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
          tick_q |=> !tick_q); // R9
      end
    end else begin : g_ext
      logic tick_q;
      always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= ext_tick;
      end
      assign tick = tick_q;
    end
  endgenerate
endmodule

// File: rtl/vs_range_latch.sv
module vs_range_latch
  import vs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  vs_range_t flags,
  output vs_range_t seen
);
  vs_range_t sticky_q;

  assign seen.low  = sticky_q.low  | flags.low;
  assign seen.high = sticky_q.high | flags.high;

  always_ff @(posedge clk) begin
    if (rst || tick) sticky_q <= '0;
    else             sticky_q <= seen;
  end

  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    tick |=> (sticky_q == '0)); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && sticky_q.low) |=> sticky_q.low); // R6
endmodule

// File: rtl/vs_skip_counter.sv
module vs_skip_counter
  import vs_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             surge,
  input  vs_range_t        seen,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (surge)
      cnt_d = ONE;
    else if (tick) begin
      if (seen.high)
        cnt_d = (cnt_q > ONE) ? cnt_q - ONE : ONE;
      else if (seen.low)
        cnt_d = (cnt_q < TOP) ? cnt_q + ONE : TOP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= ONE;
    else     cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0); // R8
  AST_SURGE_ONE: assert property (@(posedge clk) disable iff (rst)
    surge |=> (cnt_q == ONE)); // R5
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !surge) |=> $stable(cnt_q)); // R4
  AST_DOWN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (tick && !surge && seen.high && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE)); // R7
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && !surge && !seen.high && seen.low && cnt_q < TOP) |=> (cnt_q == $past(cnt_q) + ONE)); // R2
endmodule

// File: rtl/valley_skip_ctrl.sv
module valley_skip_ctrl
  import vs_pkg::*;
#(
  parameter int unsigned CNT_W         = 4,
  parameter bit          TICK_INTERNAL = 1'b1,
  parameter int unsigned TICK_DIV      = 5000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fb_low,
  input  logic             fb_high,
  input  logic             fb_surge,
  input  logic             ext_tick,
  output logic [CNT_W-1:0] skip_cnt
);
  logic      tick;
  vs_range_t flags, seen;

  assign flags.low  = fb_low;
  assign flags.high = fb_high;

  vs_tick_gen #(
    .TICK_INTERNAL(TICK_INTERNAL),
    .TICK_DIV     (TICK_DIV)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .ext_tick(ext_tick),
    .tick    (tick)
  );

  vs_range_latch u_latch (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .flags(flags),
    .seen (seen)
  );

  vs_skip_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .surge(fb_surge),
    .seen (seen),
    .cnt  (skip_cnt)
  );

  AST_RESET_ONE: assert property (@(posedge clk)
    rst |=> (skip_cnt == CNT_W'(1))); // R1
endmodule

// File: tb/valley_skip_ctrl_tb.sv
module valley_skip_ctrl_tb;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fb_low = 1'b0, fb_high = 1'b0, fb_surge = 1'b0, ext_tick = 1'b0;
  logic [3:0] skip_cnt;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  valley_skip_ctrl #(.CNT_W(4), .TICK_INTERNAL(1'b1), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .fb_low(fb_low), .fb_high(fb_high),
    .fb_surge(fb_surge), .ext_tick(ext_tick), .skip_cnt(skip_cnt)
  );

  // Reference built from the requirements: tick in the cycle after every
  // DIV-th edge since reset (R9), sticky capture (R6), priorities (R5, R7),
  // limits (R8).
  int m_div, m_cnt, m_edges;
  bit m_tick, m_lo, m_hi;

  function automatic int step(int c, bit tk, bit lo, bit hi, bit sg);
    if (sg) return 1;
    if (!tk) return c;
    if (hi) return (c > 1) ? c - 1 : 1;
    if (lo) return (c < 15) ? c + 1 : 15;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_div <= 0; m_tick <= 1'b0; m_lo <= 1'b0; m_hi <= 1'b0; m_cnt <= 1; m_edges <= 0;
    end else begin
      m_edges <= m_edges + 1;
      m_div   <= (m_div == DIV - 1) ? 0 : m_div + 1;
      m_tick  <= ((m_edges + 1) % DIV) == 0;
      m_lo    <= m_tick ? 1'b0 : (m_lo | fb_low);
      m_hi    <= m_tick ? 1'b0 : (m_hi | fb_high);
      m_cnt   <= step(m_cnt, m_tick, m_lo | fb_low, m_hi | fb_high, fb_surge);
    end
  end

  task automatic check(input int exp, input string req);
    n_run++;
    if (int'(skip_cnt) != exp) begin
      n_fail++;
      $display("FAIL %s: skip_cnt=%0d expected=%0d at %0t", req, skip_cnt, exp, $time);
    end
  endtask

  // Compare every cycle against the reference; req tag picks the reason.
  task automatic cyc(input bit lo, input bit hi, input bit sg, input string req);
    fb_low = lo; fb_high = hi; fb_surge = sg;
    @(negedge clk);
    check(m_cnt, req);
  endtask

  task automatic periods(input int n, input bit lo, input bit hi, input string req);
    for (int i = 0; i < n * DIV; i++) cyc(lo, hi, 1'b0, req);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(1, "R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check(1, "R1 after reset");

    // R9: first tick after DIV edges; count must stay at 1 with no flags (R4)
    periods(2, 1'b0, 1'b0, "R4 hold");
    check(1, "R4 idle value");

    // R2 + R8: run up to the upper limit
    periods(20, 1'b1, 1'b0, "R2 step up");
    check(15, "R8 upper limit");

    // R3 + R8: run down to the lower limit
    periods(3, 1'b0, 1'b1, "R3 step down");
    periods(20, 1'b0, 1'b1, "R3 step down");
    check(1, "R8 lower limit");

    // R6: single-cycle low pulse early in period, then quiet
    periods(1, 1'b0, 1'b0, "R4 hold");
    cyc(1'b1, 1'b0, 1'b0, "R6 pulse");
    for (int i = 0; i < 3 * DIV; i++) cyc(1'b0, 1'b0, 1'b0, "R6 once");
    check(2, "R6 pulse acted on once");

    // R7: both seen in one period -> decrement
    periods(4, 1'b1, 1'b0, "R2 step up");
    check(6, "R2 directed value");
    cyc(1'b1, 1'b0, 1'b0, "R7 mix");
    cyc(1'b0, 1'b1, 1'b0, "R7 mix");
    for (int i = 0; i < 2 * DIV; i++) cyc(1'b0, 1'b0, 1'b0, "R7 both");
    check(5, "R7 decrement wins");

    // R5: surge resets at once, mid-period
    cyc(1'b0, 1'b0, 1'b1, "R5 surge");
    check(1, "R5 surge to one");

    // Random mix of sparse pulses and rare surges
    for (int i = 0; i < 4000; i++) begin
      bit lo, hi, sg;
      lo = ($urandom % 11) == 0;
      hi = ($urandom % 17) == 0;
      sg = ($urandom % 300) == 0;
      if (i % 800 < 300) lo = 1'b1;
      cyc(lo, hi, sg, "R2/R3/R5/R6/R7/R8 random");
    end

    // Reset mid-run
    rst = 1'b1;
    @(negedge clk);
    check(1, "R1 reset mid-run");
    rst = 1'b0;
    periods(1, 1'b0, 1'b0, "R4 hold");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule